// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an external asynchronous static RAM of 2^18 words by 16 bits with a shared data bus. The host hands it one request at a time through a ready/valid handshake. Each request carries a read/write flag, a word address, write data and a per-byte lane mask. The controller latches the request and runs the chip-select, write-enable, output-enable and lane-enable strobes through a fixed sequence of phases. It then returns a one-cycle done pulse, with the read word on a read.

The length of each phase is a parameter given in clock cycles. A user picks these counts by rounding the memory's nanosecond limits up to whole cycles of the chosen clock. Writes are timed by the write-enable strobe, and output enable stays high throughout every write. The controller turns on its own data drivers only after a turnaround gap, so the memory and the controller never drive the bus in the same cycle. Byte lanes that the mask excludes never see their enable strobe, and they read back as zero.

Top module: `sram_ctrl`

## Requirements
- R1: Under reset and on leaving it, chip select, write enable and output enable are high, both lane enables are high, the data driver is off, `req_ready_o` is high and `rsp_valid_o` is low.
- R2: A read accepted at clock edge E0 holds chip select and output enable low for RD_ACCESS_CYC cycles. `rsp_valid_o` is high in the cycle after edge E0+RD_ACCESS_CYC.
- R3: Mask bit 0 selects data bits 7:0 and drives `mem_be_no[0]` low; mask bit 1 selects bits 15:8 and drives `mem_be_no[1]` low. Lane enables are low only while chip select is low. Read data in a lane that is not selected is zero.
- R4: A write changes only the selected lanes of the addressed word; the other lane keeps its earlier content.
- R5: Write enable is low for exactly WR_PULSE_CYC consecutive cycles per write. Throughout that window chip select is low, output enable is high and the write data is driven.
- R6: The data driver is never on while output enable is low, nor within TURN_CYC cycles after output enable rises.
- R7: After a write is accepted, the driver turns on after TURN_CYC cycles with chip select low and drivers off. Write enable falls WR_SETUP_CYC cycles after the driver turns on. The data stays driven for one cycle after write enable rises.
- R8: The memory address, the lane enables and the driven data stay equal to the accepted request for the whole time chip select is low, even when the host inputs change.
- R9: `req_ready_o` is low from acceptance until the access ends. It rises again TURN_CYC cycles after a read's done pulse, and together with a write's done pulse.
- R10: A request with mask 00 asserts no lane enable. A write with mask 00 leaves memory unchanged, and a read with mask 00 returns zero.
- R11: Each request produces exactly one single-cycle done pulse. A write's pulse comes TURN_CYC+WR_SETUP_CYC+WR_PULSE_CYC+2 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_be_i | input | DATA_W/8 | Lane mask, bit k selects bits 8k+7:8k |
| rsp_valid_o | output | 1 | Done pulse, one cycle |
| rsp_rdata_o | output | DATA_W | Read data, unselected lanes zero |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_be_no | output | DATA_W/8 | Lane enables, active low |
| mem_dq_o | output | DATA_W | Data toward memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
A sequencer that stays in a phase too long or too short shows up at the pins within that same access. The cycle in which the driver turns on, the cycle in which write enable falls, or the index of the done pulse shifts away from its count since acceptance. A wrong lane or address register appears as lane enables or an address that differ from the request while chip select is low, or as a wrong word on the next read-back. A turnaround fault is visible in the first write that follows a read, as driver-on cycles too close to the rise of output enable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STB_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctrl_cnt.sv
module sram_ctrl_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_ACCESS_CYC = 2,
  parameter int unsigned WR_PULSE_CYC  = 1,
  parameter int unsigned WR_SETUP_CYC  = 1,
  parameter int unsigned TURN_CYC      = 1,
  parameter int          CNT_W         = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             cnt_zero_i,
  output logic             ready_o,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output state_e           state_d_o,
  output logic             capture_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] WS_LD = CNT_W'(WR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TURN_CYC - 1);

  state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    capture_o  = 1'b0;
    done_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        cnt_load_o = 1'b1;
        if (req_write_i) begin
          state_d   = ST_WR_TURN;
          cnt_val_o = TA_LD;
        end else begin
          state_d   = ST_RD_ACC;
          cnt_val_o = RD_LD;
        end
      end
      ST_RD_ACC: if (cnt_zero_i) begin
        state_d    = ST_RD_TURN;
        cnt_load_o = 1'b1;
        cnt_val_o  = TA_LD;
        capture_o  = 1'b1;
        done_o     = 1'b1;
      end
      ST_RD_TURN: if (cnt_zero_i) state_d = ST_IDLE;
      ST_WR_TURN: if (cnt_zero_i) begin
        state_d    = ST_WR_SETUP;
        cnt_load_o = 1'b1;
        cnt_val_o  = WS_LD;
      end
      ST_WR_SETUP: if (cnt_zero_i) begin
        state_d    = ST_WR_PULSE;
        cnt_load_o = 1'b1;
        cnt_val_o  = WP_LD;
      end
      ST_WR_PULSE: if (cnt_zero_i) state_d = ST_WR_HOLD;
      ST_WR_HOLD: begin
        state_d = ST_IDLE;
        done_o  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign state_d_o = state_d;

  // R11: a completion never follows another completion directly
  a_r11_done_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io
  import sram_ctrl_pkg::*;
#(
  parameter int          ADDR_W   = 18,
  parameter int          DATA_W   = 16,
  parameter int          LANES    = 2,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  state_e            state_d_i,
  input  logic              capture_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [LANES-1:0]  mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  localparam int TW = $clog2(TURN_CYC + 1) + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  be_q, be_nxt, lane_n_q;
  strobe_t           stb_d, stb_q;
  logic              lanes_on, done_q;

  assign be_nxt = accept_i ? be_i : be_q;

  always_comb begin
    stb_d    = STB_IDLE;
    lanes_on = 1'b0;
    unique case (state_d_i)
      ST_RD_ACC:   begin stb_d = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0}; lanes_on = 1'b1; end
      ST_WR_TURN:  begin stb_d = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0}; lanes_on = 1'b1; end
      ST_WR_SETUP: begin stb_d = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1}; lanes_on = 1'b1; end
      ST_WR_PULSE: begin stb_d = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1}; lanes_on = 1'b1; end
      ST_WR_HOLD:  begin stb_d = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1}; lanes_on = 1'b1; end
      default:     stb_d = STB_IDLE;
    endcase
  end

  // strobes come straight from flops: no decode glitches at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      stb_q    <= STB_IDLE;
      lane_n_q <= '1;
      done_q   <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
      stb_q    <= stb_d;
      lane_n_q <= lanes_on ? ~be_nxt : '1;
      done_q   <= done_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rdata_q[g*8 +: 8] <= '0;
      else if (capture_i) rdata_q[g*8 +: 8] <= be_q[g] ? mem_dq_i[g*8 +: 8] : 8'h00;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = stb_q.ce_n;
  assign mem_we_no   = stb_q.we_n;
  assign mem_oe_no   = stb_q.oe_n;
  assign mem_be_no   = lane_n_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = stb_q.drv;
  assign rsp_valid_o = done_q;
  assign rsp_rdata_o = rdata_q;

  // cycles output enable has been high, saturating: checker state
  logic [TW-1:0] oe_hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          oe_hi_cnt <= TW'(TURN_CYC);
    else if (!stb_q.oe_n)                 oe_hi_cnt <= '0;
    else if (oe_hi_cnt < TW'(TURN_CYC))   oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  a_r5_we_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no && mem_dq_oe_o));

  a_r6_no_drive_oe_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  a_r6_turn_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (oe_hi_cnt >= TW'(TURN_CYC)));

  a_r7_data_before_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> $past(mem_dq_oe_o));

  a_r7_data_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o);

  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)
                                           && $stable(mem_be_no)));

  a_r3_lanes_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> (&mem_be_no));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int          ADDR_W        = 18,
  parameter int          DATA_W        = 16,
  parameter int unsigned RD_ACCESS_CYC = 2,
  parameter int unsigned WR_PULSE_CYC  = 1,
  parameter int unsigned WR_SETUP_CYC  = 1,
  parameter int unsigned TURN_CYC      = 1,
  localparam int         LANES         = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [LANES-1:0]  mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned MAX_CYC = max4(RD_ACCESS_CYC, WR_PULSE_CYC, WR_SETUP_CYC, TURN_CYC);
  localparam int          CNT_W   = $clog2(MAX_CYC) + 1;

  logic             cnt_load, cnt_zero, capture, done, accept;
  logic [CNT_W-1:0] cnt_val;
  state_e           state_d;

  assign accept = req_valid_i && req_ready_o;

  sram_ctrl_fsm #(
    .RD_ACCESS_CYC(RD_ACCESS_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .WR_SETUP_CYC (WR_SETUP_CYC),
    .TURN_CYC     (TURN_CYC),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .cnt_zero_i (cnt_zero),
    .ready_o    (req_ready_o),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .state_d_o  (state_d),
    .capture_o  (capture),
    .done_o     (done)
  );

  sram_ctrl_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cnt_load),
    .val_i (cnt_val),
    .zero_o(cnt_zero)
  );

  sram_ctrl_io #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LANES   (LANES),
    .TURN_CYC(TURN_CYC)
  ) u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .be_i       (req_be_i),
    .state_d_i  (state_d),
    .capture_i  (capture),
    .done_i     (done),
    .mem_addr_o (mem_addr_o),
    .mem_ce_no  (mem_ce_no),
    .mem_we_no  (mem_we_no),
    .mem_oe_no  (mem_oe_no),
    .mem_be_no  (mem_be_no),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i   (mem_dq_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  // R9: strobes are idle whenever a new request may be taken
  a_r9_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && !mem_dq_oe_o));

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int RD = 3;
  localparam int WP = 2;
  localparam int WS = 1;
  localparam int TA = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o, mem_dq_i;

  int checks = 0;
  int failures = 0;
  int contention = 0;
  int since_rd = 255;

  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];

  always #4 clk = ~clk;

  sram_ctrl #(
    .RD_ACCESS_CYC(RD), .WR_PULSE_CYC(WP), .WR_SETUP_CYC(WS), .TURN_CYC(TA)
  ) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n), .mem_oe_no(mem_oe_n),
    .mem_be_no(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model: drives selected lanes on read, filler 8'hEE elsewhere
  wire mem_rd = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = mem_rd ? {(!mem_be_n[1] ? mem[mem_addr[7:0]][15:8] : 8'hEE),
                              (!mem_be_n[0] ? mem[mem_addr[7:0]][7:0]  : 8'hEE)} : 16'hEEEE;

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n && mem_dq_oe) begin
      if (!mem_be_n[0]) mem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
      if (!mem_be_n[1]) mem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
    end
  end

  // bus contention: memory may keep driving up to TA cycles after output enable rises
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) since_rd = 0;
      else if (since_rd < 255) since_rd = since_rd + 1;
      if (mem_dq_oe && (mem_rd || since_rd <= TA)) contention = contention + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1", "strobes idle", {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 32'h1f);
    check(req_ready && !rsp_valid, "R1", "ready/valid", {30'd0, req_ready, rsp_valid}, 32'h2);
  endtask

  // one read; checks timing, lanes, data, stability, handshake
  task automatic do_read(input logic [17:0] a, input logic [1:0] be);
    logic [15:0] exp, got;
    int done_idx, ready_idx, pulses;
    bit stable_ok, busy_ok, lane_ok;
    exp = {be[1] ? exp_mem[a[7:0]][15:8] : 8'h00, be[0] ? exp_mem[a[7:0]][7:0] : 8'h00};
    done_idx = 0; ready_idx = 0; pulses = 0; got = '0;
    stable_ok = 1; busy_ok = 1; lane_ok = 1;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be; req_wdata = 16'h1234;
    @(posedge clk);
    for (int idx = 1; idx < 100; idx++) begin
      @(negedge clk);
      if (idx == 1) begin
        req_valid = 0; req_addr = ~a; req_be = ~be; req_wdata = 16'hFFFF;
      end
      if (rsp_valid) begin pulses++; done_idx = idx; got = rsp_rdata; end
      if (!mem_ce_n) begin
        if (mem_addr != a) stable_ok = 0;
        if (mem_be_n != ~be) lane_ok = 0;
      end
      if (!mem_we_n || mem_dq_oe) stable_ok = 0;
      if (req_ready) begin ready_idx = idx; break; end
      else if (idx > RD + TA + 1) busy_ok = 0;
    end
    check(done_idx == RD + 1, "R2", "read done index", done_idx, RD + 1);
    check(got == exp, "R2", "read data", got, exp);
    check(lane_ok, "R3", "lane enables during read", mem_be_n, ~be);
    check(stable_ok, "R8", "read address stable", mem_addr, a);
    check(busy_ok && ready_idx == RD + TA + 1, "R9", "ready after read", ready_idx, RD + TA + 1);
    check(pulses == 1, "R11", "read done pulses", pulses, 1);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
    int drv_idx, we_idx, we_cnt, done_idx, ready_idx, pulses;
    bit win_ok, stable_ok, lane_ok, hold_ok;
    logic prev_we;
    drv_idx = 0; we_idx = 0; we_cnt = 0; done_idx = 0; ready_idx = 0; pulses = 0;
    win_ok = 1; stable_ok = 1; lane_ok = 1; hold_ok = 0; prev_we = 1;
    if (be[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
    if (be[1]) exp_mem[a[7:0]][15:8] = d[15:8];
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
    @(posedge clk);
    for (int idx = 1; idx < 100; idx++) begin
      @(negedge clk);
      if (idx == 1) begin
        req_valid = 0; req_write = 0; req_addr = ~a; req_be = ~be; req_wdata = ~d;
      end
      if (mem_dq_oe && drv_idx == 0) drv_idx = idx;
      if (!mem_we_n) begin
        if (we_idx == 0) we_idx = idx;
        we_cnt++;
        if (mem_ce_n || !mem_oe_n || !mem_dq_oe) win_ok = 0;
      end
      if (mem_we_n && !prev_we && mem_dq_oe && !mem_ce_n) hold_ok = 1;
      prev_we = mem_we_n;
      if (!mem_ce_n) begin
        if (mem_addr != a || mem_be_n != ~be) lane_ok = 0;
        if (mem_dq_oe && mem_dq_o != d) stable_ok = 0;
      end
      if (rsp_valid) begin pulses++; done_idx = idx; end
      if (req_ready) begin ready_idx = idx; break; end
    end
    check(drv_idx == TA + 1, "R7", "driver-on index", drv_idx, TA + 1);
    check(we_idx == TA + WS + 1, "R7", "write enable fall index", we_idx, TA + WS + 1);
    check(hold_ok, "R7", "data held after write enable rise", hold_ok, 1);
    check(we_cnt == WP && win_ok, "R5", "write pulse cycles", we_cnt, WP);
    check(lane_ok && stable_ok, "R8", "write address/lanes/data stable", mem_dq_o, d);
    check(done_idx == TA + WS + WP + 2 && pulses == 1, "R11", "write done index",
          done_idx, TA + WS + WP + 2);
    check(ready_idx == done_idx, "R9", "ready after write", ready_idx, done_idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = {8'(i) ^ 8'h5A, 8'(i) + 8'h31};
      exp_mem[i] = {8'(i) ^ 8'h5A, 8'(i) + 8'h31};
    end
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_reset();

    do_read(18'h00005, 2'b11);                // R2 full word
    do_read(18'h00009, 2'b01);                // R3 lower lane only
    do_read(18'h0000A, 2'b10);                // R3 upper lane only
    do_write(18'h00014, 2'b11, 16'hBEEF);     // R4 full word
    do_read(18'h00014, 2'b11);
    do_write(18'h00021, 2'b10, 16'hC3A5);     // R4 upper only, lower kept
    do_read(18'h00021, 2'b11);
    do_write(18'h00022, 2'b01, 16'h7E81);     // R4 lower only
    do_read(18'h00022, 2'b11);
    do_write(18'h00028, 2'b00, 16'h0F0F);     // R10 no lanes written
    do_read(18'h00028, 2'b11);
    do_read(18'h00028, 2'b00);                // R10 read with empty mask is zero
    check(rsp_rdata == 16'h0000, "R10", "empty mask read data", rsp_rdata, 16'h0000);
    do_write(18'h3FFFF, 2'b11, 16'h55AA);     // top address, read right after write
    do_read(18'h3FFFF, 2'b11);
    check(mem[8'hFF] == 16'h55AA, "R4", "top word in memory", mem[8'hFF], 16'h55AA);
    check(contention == 0, "R6", "bus contention cycles", contention, 0);

    summary();
    $finish;
  end

endmodule